// File: doc/BRIEF.md
# Conditioned Loop Current Filter

This block forms a subscriber loop current from four signed branch-current samples and then smooths it with a programmable first-order digital low-pass filter. Each sample set arrives with a one-cycle valid strobe. A common-mode-high flag and a 3-bit linefeed state code control the combination. When the flag is set, the first or the second branch current is dropped, depending on the linefeed state. The combined sum is halved in every state except the two open states.

Both the unfiltered loop current and the filtered value are registered and presented together, one clock after the input strobe. A companion strobe marks them. A 16-bit coefficient sets the filter's cutoff, with 0x4000 meaning unity gain. The block is meant to feed a threshold comparator that sits downstream.

Top module: `loop_current_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0 and `loop_raw` and `loop_filt` are zero.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high.
- R3: For linefeed codes other than 3 and 7, `loop_raw` equals the sum of the four currents (after masking) shifted right arithmetically by one bit.
- R4: For linefeed code 3 (tip-open) and code 7 (ring-open), `loop_raw` equals the masked sum of the four currents, unscaled.
- R5: With `cm_high` = 1 and linefeed code 1 (forward active) or 3 (tip-open), `cur_a` contributes zero.
- R6: With `cm_high` = 1 and linefeed code 5 (reverse active) or 7 (ring-open), `cur_b` contributes zero.
- R7: With `cm_high` = 0, or with any other linefeed code, all four currents contribute at their full value.
- R8: On each valid sample the filter value y is updated as follows. The filter input x is `loop_raw` saturated to 16 signed bits. The new y is y + ((coef × (x − y)) >>> 14), using a floor arithmetic shift, and the result is saturated to 16 signed bits.
- R9: With coef = 0x0000, `loop_filt` does not change on a valid sample, so it stays zero after reset.
- R10: With coef = 0x4000, `loop_filt` equals the saturated filter input of that sample.
- R11: In a cycle after `in_valid` was low, `loop_raw` and `loop_filt` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample-valid strobe |
| cur_a | input | 16 | Signed branch current A, masked in codes 1 and 3 |
| cur_b | input | 16 | Signed branch current B, masked in codes 5 and 7 |
| cur_c | input | 16 | Signed branch current C |
| cur_d | input | 16 | Signed branch current D |
| cm_high | input | 1 | Common-mode-high flag |
| lf_state | input | 3 | Linefeed state code |
| coef | input | 16 | Unsigned filter coefficient, 0x4000 is unity |
| loop_raw | output | 18 | Signed conditioned loop current |
| loop_filt | output | 16 | Signed filtered loop current |
| out_valid | output | 1 | Result-valid strobe |

## Verification
A sample presented with `in_valid` at one rising edge produces all three results registered at that same edge. The results are therefore due in the following cycle. The bench updates its behavioural model at each rising edge from the inputs it is holding at that moment. It compares `out_valid`, `loop_raw` and `loop_filt` at the next falling edge, before it changes any input. Idle cycles between samples show whether the results are held.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

   localparam int LF_W = 3;

   // Linefeed codes that affect the loop current
   localparam logic [LF_W-1:0] LF_FWD_ACTIVE = 3'd1;
   localparam logic [LF_W-1:0] LF_TIP_OPEN   = 3'd3;
   localparam logic [LF_W-1:0] LF_REV_ACTIVE = 3'd5;
   localparam logic [LF_W-1:0] LF_RING_OPEN  = 3'd7;

   function automatic logic is_open_state(input logic [LF_W-1:0] lf);
      return (lf == LF_TIP_OPEN) || (lf == LF_RING_OPEN);
   endfunction

   function automatic logic drop_branch_a(input logic cm, input logic [LF_W-1:0] lf);
      return cm && ((lf == LF_FWD_ACTIVE) || (lf == LF_TIP_OPEN));
   endfunction

   function automatic logic drop_branch_b(input logic cm, input logic [LF_W-1:0] lf);
      return cm && ((lf == LF_REV_ACTIVE) || (lf == LF_RING_OPEN));
   endfunction

endpackage

// File: rtl/lcf_condition.sv
module lcf_condition
   import lcf_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int RAW_W = IN_W + 2
) (
   input  logic signed [IN_W-1:0]  cur_a,
   input  logic signed [IN_W-1:0]  cur_b,
   input  logic signed [IN_W-1:0]  cur_c,
   input  logic signed [IN_W-1:0]  cur_d,
   input  logic                    cm_high,
   input  logic [LF_W-1:0]         lf_state,
   output logic signed [RAW_W-1:0] raw
);

   localparam int NBR = 4;

   generate
      if (RAW_W < IN_W + 2) begin : g_bad_raw_w
         $error("lcf_condition: RAW_W must hold the sum of four inputs");
      end
   endgenerate

   logic signed [IN_W-1:0]  branch [NBR];
   logic                    keep   [NBR];
   logic signed [RAW_W-1:0] term   [NBR];
   logic signed [RAW_W-1:0] total;

   always_comb begin
      branch[0] = cur_a;
      branch[1] = cur_b;
      branch[2] = cur_c;
      branch[3] = cur_d;
      keep[0]   = !drop_branch_a(cm_high, lf_state);
      keep[1]   = !drop_branch_b(cm_high, lf_state);
      keep[2]   = 1'b1;
      keep[3]   = 1'b1;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NBR; gi++) begin : g_term
         assign term[gi] = keep[gi] ? RAW_W'(branch[gi]) : '0;
      end
   endgenerate

   always_comb begin
      total = '0;
      for (int k = 0; k < NBR; k++) begin
         total = total + term[k];
      end
      raw = is_open_state(lf_state) ? total : (total >>> 1);
   end

endmodule

// File: rtl/lcf_lowpass.sv
module lcf_lowpass #(
   parameter int IN_W   = 16,
   parameter int RAW_W  = IN_W + 2,
   parameter int COEF_W = 16,
   parameter int FRAC   = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [RAW_W-1:0] x_raw,
   input  logic [COEF_W-1:0]       coef,
   output logic signed [IN_W-1:0]  y
);

   localparam int DIFF_W = IN_W + 1;
   localparam int PROD_W = DIFF_W + COEF_W + 1;
   localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC;
   localparam logic signed [RAW_W-1:0]  RAW_MAX = RAW_W'((64'sd1 <<< (IN_W-1)) - 1);
   localparam logic signed [RAW_W-1:0]  RAW_MIN = -RAW_W'(64'sd1 <<< (IN_W-1));
   localparam logic signed [PROD_W-1:0] ACC_MAX = PROD_W'((64'sd1 <<< (IN_W-1)) - 1);
   localparam logic signed [PROD_W-1:0] ACC_MIN = -PROD_W'(64'sd1 <<< (IN_W-1));

   generate
      if (FRAC >= COEF_W) begin : g_bad_frac
         $error("lcf_lowpass: unity coefficient must fit in COEF_W");
      end
      if (IN_W < 4 || IN_W > 30) begin : g_bad_in_w
         $error("lcf_lowpass: IN_W out of supported range");
      end
      if (RAW_W <= IN_W) begin : g_bad_raw_w
         $error("lcf_lowpass: RAW_W must exceed IN_W");
      end
   endgenerate

   logic signed [IN_W-1:0]   x_sat;
   logic signed [DIFF_W-1:0] diff;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] acc;
   logic signed [IN_W-1:0]   y_next;

   always_comb begin
      if (x_raw > RAW_MAX)      x_sat = IN_W'(RAW_MAX);
      else if (x_raw < RAW_MIN) x_sat = IN_W'(RAW_MIN);
      else                      x_sat = IN_W'(x_raw);
   end

   always_comb begin
      diff = DIFF_W'(x_sat) - DIFF_W'(y);
      prod = $signed({1'b0, coef}) * diff;
      acc  = PROD_W'(y) + (prod >>> FRAC);
      if (acc > ACC_MAX)      y_next = IN_W'(ACC_MAX);
      else if (acc < ACC_MIN) y_next = IN_W'(ACC_MIN);
      else                    y_next = IN_W'(acc);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  y <= '0;
      else if (en) y <= y_next;
   end

   // R9
   zero_coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && coef == '0) |=> $stable(y));

   // R10
   unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && coef == UNITY) |=> (y == $past(x_sat)));

   // R11
   idle_filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(y));

endmodule

// File: rtl/loop_current_filter.sv
module loop_current_filter
   import lcf_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int COEF_W = 16,
   parameter int FRAC   = 14,
   localparam int RAW_W = IN_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  cur_a,
   input  logic signed [IN_W-1:0]  cur_b,
   input  logic signed [IN_W-1:0]  cur_c,
   input  logic signed [IN_W-1:0]  cur_d,
   input  logic                    cm_high,
   input  logic [LF_W-1:0]         lf_state,
   input  logic [COEF_W-1:0]       coef,
   output logic signed [RAW_W-1:0] loop_raw,
   output logic signed [IN_W-1:0]  loop_filt,
   output logic                    out_valid
);

   logic signed [RAW_W-1:0] raw_comb;

   lcf_condition #(
      .IN_W  (IN_W),
      .RAW_W (RAW_W)
   ) u_cond (
      .cur_a    (cur_a),
      .cur_b    (cur_b),
      .cur_c    (cur_c),
      .cur_d    (cur_d),
      .cm_high  (cm_high),
      .lf_state (lf_state),
      .raw      (raw_comb)
   );

   lcf_lowpass #(
      .IN_W   (IN_W),
      .RAW_W  (RAW_W),
      .COEF_W (COEF_W),
      .FRAC   (FRAC)
   ) u_lpf (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .x_raw (raw_comb),
      .coef  (coef),
      .y     (loop_filt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loop_raw  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) loop_raw <= raw_comb;
      end
   end

   // R2
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R11
   idle_raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(loop_raw));

   // R5
   tip_open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cm_high && lf_state == LF_TIP_OPEN) |=>
      (loop_raw == $past(RAW_W'(cur_b) + RAW_W'(cur_c) + RAW_W'(cur_d))));

   // R6
   ring_open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cm_high && lf_state == LF_RING_OPEN) |=>
      (loop_raw == $past(RAW_W'(cur_a) + RAW_W'(cur_c) + RAW_W'(cur_d))));

endmodule

// File: tb/loop_current_filter_bench.sv
`timescale 1ns/1ps
module loop_current_filter_bench;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] cur_a = '0, cur_b = '0, cur_c = '0, cur_d = '0;
   logic               cm_high = 1'b0;
   logic [2:0]         lf_state = 3'd1;
   logic [15:0]        coef = 16'h4000;
   logic signed [17:0] loop_raw;
   logic signed [15:0] loop_filt;
   logic               out_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   int m_raw = 0;
   int m_filt = 0;
   bit m_vld = 0;

   always #2.5 clk = ~clk;

   loop_current_filter u_loop_current_filter (
      .clk, .rst_n, .in_valid, .cur_a, .cur_b, .cur_c, .cur_d,
      .cm_high, .lf_state, .coef, .loop_raw, .loop_filt, .out_valid
   );

   function automatic longint clamp16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         m_raw = 0; m_filt = 0; m_vld = 0;
      end else begin
         m_vld = in_valid;
         if (in_valid) begin
            int a, b, s, r;
            longint x, p;
            a = (cm_high && (lf_state == 3'd1 || lf_state == 3'd3)) ? 0 : int'(cur_a);
            b = (cm_high && (lf_state == 3'd5 || lf_state == 3'd7)) ? 0 : int'(cur_b);
            s = a + b + int'(cur_c) + int'(cur_d);
            r = (lf_state == 3'd3 || lf_state == 3'd7) ? s : (s >>> 1);
            m_raw = r;
            x = clamp16(longint'(r));
            p = longint'(coef) * (x - longint'(m_filt));
            m_filt = int'(clamp16(longint'(m_filt) + (p >>> 14)));
         end
      end
   endtask

   task automatic compare(input string tag);
      n_chk++;
      if (out_valid !== m_vld || int'(loop_raw) != m_raw || int'(loop_filt) != m_filt) begin
         n_bad++;
         $display("FAIL %s: vld/raw/filt actual %0b/%0d/%0d expected %0b/%0d/%0d",
                  tag, out_valid, loop_raw, loop_filt, m_vld, m_raw, m_filt);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic sample(input string tag, input logic cm, input logic [2:0] lf,
                         input int a, input int b, input int c, input int d);
      in_valid = 1'b1; cm_high = cm; lf_state = lf;
      cur_a = 16'(a); cur_b = 16'(b); cur_c = 16'(c); cur_d = 16'(d);
      step(tag);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) step("R1 reset");
      rst_n = 1'b1;
      step("R1 first cycle after reset");
      // R3 R10: forward active, unity coefficient, odd and negative sums
      coef = 16'h4000;
      sample("R3 R10 fwd", 1'b0, 3'd1, 100, 200, 30, 7);
      step("R2 strobe drop");
      sample("R3 R10 negative odd", 1'b0, 3'd5, -3, 0, 0, 0);
      sample("R3 state0", 1'b0, 3'd0, -1000, 250, -17, 999);
      // R4 R7: open states without common-mode
      sample("R4 R7 tip-open", 1'b0, 3'd3, 1111, 2222, 333, 44);
      sample("R4 R7 ring-open", 1'b0, 3'd7, -500, 600, -70, 8);
      // R5 masking
      sample("R5 fwd masked", 1'b1, 3'd1, 5000, 40, 30, 21);
      sample("R5 R4 tip-open masked", 1'b1, 3'd3, -9000, 40, 30, 20);
      // R6 masking
      sample("R6 rev masked", 1'b1, 3'd5, 40, 7000, 30, 21);
      sample("R6 R4 ring-open masked", 1'b1, 3'd7, 40, -7000, 30, 20);
      // R7 cm set but state masks nothing
      sample("R7 cm state2", 1'b1, 3'd2, 101, 202, 303, 404);
      sample("R7 cm state6", 1'b1, 3'd6, 101, 202, 303, 404);
      // R11 idle hold
      cur_a = 16'sd1234; cur_b = 16'sd99; lf_state = 3'd3;
      repeat (3) step("R11 idle hold");
      // R8 saturation of filter input
      sample("R8 R4 positive saturation", 1'b0, 3'd3, 32767, 32767, 32767, 32767);
      sample("R8 R4 negative saturation", 1'b0, 3'd7, -32768, -32768, -32768, -32768);
      // R8 smoothing with a mid coefficient
      coef = 16'h0A10;
      for (int i = 0; i < 12; i++) begin
         sample("R8 step response", 1'b0, 3'd1, 8000, 6000, 100, 50);
         step("R11 gap");
      end
      for (int i = 0; i < 6; i++)
         sample("R8 alternating", 1'b0, (i % 2) ? 3'd3 : 3'd5, -4000 + 1500*i, 300, -20*i, 7);
      coef = 16'hFFFF;
      sample("R8 overshoot saturation", 1'b0, 3'd3, 32767, 32767, 0, 0);
      sample("R8 overshoot negative", 1'b0, 3'd3, -32768, -32768, 0, 0);
      // R9 zero coefficient holds value
      coef = 16'h0000;
      sample("R9 hold nonzero", 1'b0, 3'd3, 500, 500, 500, 500);
      // R1 R9 after a fresh reset the output stays zero
      rst_n = 1'b0;
      step("R1 mid reset");
      rst_n = 1'b1;
      step("R1 after second reset");
      for (int i = 0; i < 4; i++)
         sample("R9 stays zero", 1'b0, 3'd1, 3000*i, -200, 77, 1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule